// File: doc/BRIEF.md
# Endpoint FIFO Space Allocator

This block hands out space in a shared endpoint packet memory. The memory is cut into 512-byte units, and a 128-bit occupancy map records which units are in use. When an endpoint is brought up, the caller gives its largest packet size and a slot count. The block rounds the packet size up to a power of two to get the segment size. It multiplies that by the slot count plus one to get the endpoint's buffer size, and converts the result into a whole number of units. It then walks the map from unit 0 for the first free run that is long enough. It claims that run and returns the buffer address as the pool base plus the start unit times 512.

Tearing an endpoint down is a single-cycle release that clears a run of units. The transmit and receive memories each get their own instance. Each pool has its own base address and its own usable length, given in units. A controller that supports SuperSpeed would normally request two extra slots per endpoint, and a USB2-only controller one.

Top module: `fifo_space_alloc`

## Requirements
- R1: The segment size on `resp_seg` is the smallest power of two that is not below `alloc_maxp`; a packet size of 0 or 1 gives a segment of 1.
- R2: `resp_size` equals (`alloc_slots` + 1) × segment size, and `resp_units` equals `resp_size` divided by 512, rounded up. Both are reported with every response.
- R3: A granted request reports the lowest start unit whose run of `resp_units` free units fits below the limit. It raises `done` for one cycle, and `resp_addr` equals `cfg_base` + start × 512.
- R4: Units granted to one request are never granted to a later request until they are released.
- R5: When the scan finds no fitting run, `err` is raised for one cycle with `done` low, and the occupancy is left unchanged.
- R6: When the unit count exceeds the usable length, `err` is raised in the cycle after the request, with no scan and `busy` staying low.
- R7: A release request (`free_req`, `free_start`, `free_count`) accepted while idle clears exactly the units from `free_start` up to `free_start` + `free_count` − 1, clipped at unit 127. Releasing units that are already free changes nothing else.
- R8: The usable length is `cfg_limit` units, and any value above 128 is treated as 128. No unit at or above the usable length is ever granted.
- R9: `busy` is high for one cycle per examined unit, and never for more than 128 cycles. A grant that ends at unit k shows k + 1 busy cycles, and a scan that misses shows as many busy cycles as the usable length. The response arrives the cycle after `busy` falls, and `done` and `err` are never high together.
- R10: `alloc_req` and `free_req` raised while `busy` is high have no effect.
- R11: After reset, the map is empty, `busy`, `done` and `err` are low, and the response outputs are zero.
- R12: A release and a request raised in the same idle cycle are handled with the release first, so the scan already sees the released units as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Byte address of unit 0 of this pool |
| cfg_limit | input | IDX_W+1 | Usable length of the pool, in units |
| alloc_req | input | 1 | One-cycle request to claim space |
| alloc_maxp | input | MAXP_W | Largest packet size of the endpoint, in bytes |
| alloc_slots | input | SLOT_W | Extra packet slots requested |
| free_req | input | 1 | One-cycle release request |
| free_start | input | IDX_W | First unit to release |
| free_count | input | IDX_W+1 | Number of units to release |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: space granted |
| err | output | 1 | One-cycle pulse: request refused |
| resp_addr | output | ADDR_W | Byte address of the granted run |
| resp_start | output | IDX_W | First unit of the granted run |
| resp_units | output | FIFO_W-9 | Units needed by the last request |
| resp_seg | output | MAXP_W+1 | Segment size of the last request, in bytes |
| resp_size | output | FIFO_W | Buffer size of the last request, in bytes |

## Verification
The bench fills the pool, punches holes into it and refills them. A search that is not first-fit lands outside a hole that fits, and a faulty run count either grants a hole that is too short or skips one that is long enough. Requests that need exactly 128 units, or more than 128, sit on the boundary between a full scan and an immediate refusal. A faulty comparison there either scans for nothing or refuses a request that could fit. A release clipped past the last unit, a release of units that are already free, and a release raised while a scan is running must leave a known map behind. A later grant address shows whether a design clears too much, too little, or acts on a release it should ignore. A usable length of 200 must behave like 128, and a design that does not clamp it walks past the end of the map.

// File: rtl/fifo_alloc_pkg.sv
`timescale 1ns/1ps
package fifo_alloc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    // True when unit idx lies in the run [lo, lo + n)
    function automatic logic in_run(input int unsigned idx, input int unsigned lo,
                                    input int unsigned n);
        return (idx >= lo) && (idx < lo + n);
    endfunction

endpackage

// File: rtl/fifo_size_calc.sv
`timescale 1ns/1ps
module fifo_size_calc #(
    parameter  int MAXP_W  = 16,
    parameter  int SLOT_W  = 4,
    parameter  int UNIT_LG = 9,
    localparam int SEG_W   = MAXP_W + 1,
    localparam int FIFO_W  = SEG_W + SLOT_W,
    localparam int UNITS_W = FIFO_W - UNIT_LG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAXP_W-1:0]  maxp,
    input  logic [SLOT_W-1:0]  slots,
    output logic [SEG_W-1:0]   seg,
    output logic [FIFO_W-1:0]  size,
    output logic [UNITS_W-1:0] units
);

    localparam logic [FIFO_W-1:0] UNIT_M1 = FIFO_W'((1 << UNIT_LG) - 1);
    localparam logic [FIFO_W-1:0] UNIT_B  = FIFO_W'(1 << UNIT_LG);

    logic [SEG_W-1:0]  seg_v;
    logic [FIFO_W-1:0] mult;
    logic [FIFO_W-1:0] rounded;

    // Doubling chain: stops growing once the segment covers the packet
    always_comb begin
        seg_v = SEG_W'(1);
        for (int i = 0; i < MAXP_W; i++) begin
            if (SEG_W'(maxp) > seg_v) begin
                seg_v = seg_v << 1;
            end
        end
        seg     = seg_v;
        mult    = FIFO_W'(slots) + FIFO_W'(1);
        size    = FIFO_W'(seg_v) * mult;
        rounded = size + UNIT_M1;
        units   = UNITS_W'(rounded >> UNIT_LG);
    end

    assert_seg_pow2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(seg) == 1) && (SEG_W'(maxp) <= seg) &&
        (((seg >> 1) < SEG_W'(maxp)) || (seg == SEG_W'(1))));

    assert_unit_round_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({units, {UNIT_LG{1'b0}}} >= size) &&
        ({units, {UNIT_LG{1'b0}}} < size + UNIT_B) && (units != '0));

endmodule

// File: rtl/fifo_occ_map.sv
`timescale 1ns/1ps
module fifo_occ_map #(
    parameter  int MAP_BITS = 128,
    localparam int IDX_W    = $clog2(MAP_BITS),
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_lo,
    input  logic [CNT_W-1:0]    set_n,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_lo,
    input  logic [CNT_W-1:0]    clr_n,
    output logic [MAP_BITS-1:0] map_q
);

    logic [MAP_BITS-1:0] set_mask;
    logic [MAP_BITS-1:0] clr_mask;
    logic [MAP_BITS-1:0] map_d;

    for (genvar g = 0; g < MAP_BITS; g++) begin : g_unit
        assign set_mask[g] = set_en &
            fifo_alloc_pkg::in_run(32'(g), 32'(set_lo), 32'(set_n));
        assign clr_mask[g] = clr_en &
            fifo_alloc_pkg::in_run(32'(g), 32'(clr_lo), 32'(clr_n));
    end

    always_comb begin
        map_d = (map_q & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    // A release leaves every unit of its run free
    assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((map_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/fifo_space_alloc.sv
`timescale 1ns/1ps
module fifo_space_alloc #(
    parameter  int ADDR_W   = 32,
    parameter  int MAP_BITS = 128,
    parameter  int UNIT_LG  = 9,
    parameter  int MAXP_W   = 16,
    parameter  int SLOT_W   = 4,
    localparam int IDX_W    = $clog2(MAP_BITS),
    localparam int CNT_W    = IDX_W + 1,
    localparam int SEG_W    = MAXP_W + 1,
    localparam int FIFO_W   = SEG_W + SLOT_W,
    localparam int UNITS_W  = FIFO_W - UNIT_LG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [CNT_W-1:0]   cfg_limit,
    input  logic               alloc_req,
    input  logic [MAXP_W-1:0]  alloc_maxp,
    input  logic [SLOT_W-1:0]  alloc_slots,
    input  logic               free_req,
    input  logic [IDX_W-1:0]   free_start,
    input  logic [CNT_W-1:0]   free_count,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [ADDR_W-1:0]  resp_addr,
    output logic [IDX_W-1:0]   resp_start,
    output logic [UNITS_W-1:0] resp_units,
    output logic [SEG_W-1:0]   resp_seg,
    output logic [FIFO_W-1:0]  resp_size
);
    import fifo_alloc_pkg::*;

    localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(MAP_BITS);

    typedef struct packed {
        scan_state_e        state;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   run;
        logic [CNT_W-1:0]   need;
        logic [CNT_W-1:0]   lim;
        logic [ADDR_W-1:0]  base;
        logic               done;
        logic               err;
        logic [IDX_W-1:0]   start;
        logic [ADDR_W-1:0]  addr;
        logic [UNITS_W-1:0] units;
        logic [SEG_W-1:0]   seg;
        logic [FIFO_W-1:0]  fsize;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SEG_W-1:0]    calc_seg;
    logic [FIFO_W-1:0]   calc_size;
    logic [UNITS_W-1:0]  calc_units;
    logic [MAP_BITS-1:0] map_q;
    logic [CNT_W-1:0]    eff_lim;
    logic                too_big;
    logic                bit_free;
    logic [CNT_W-1:0]    run_inc;
    logic [CNT_W-1:0]    start_full;
    logic                set_en;
    logic                clr_en;

    fifo_size_calc #(
        .MAXP_W (MAXP_W),
        .SLOT_W (SLOT_W),
        .UNIT_LG(UNIT_LG)
    ) size_i (
        .clk  (clk),
        .rst_n(rst_n),
        .maxp (alloc_maxp),
        .slots(alloc_slots),
        .seg  (calc_seg),
        .size (calc_size),
        .units(calc_units)
    );

    fifo_occ_map #(
        .MAP_BITS(MAP_BITS)
    ) map_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(set_en),
        .set_lo(ctl_d.start),
        .set_n (ctl_q.need),
        .clr_en(clr_en),
        .clr_lo(free_start),
        .clr_n (free_count),
        .map_q (map_q)
    );

    // Usable length clamp and the up-front size test
    always_comb begin
        eff_lim = (cfg_limit > FULL_LEN) ? FULL_LEN : cfg_limit;
        too_big = int'(calc_units) > int'(eff_lim);
    end

    // Quantities used by one scan step
    always_comb begin
        bit_free   = ~map_q[ctl_q.idx];
        run_inc    = ctl_q.run + CNT_W'(1);
        start_full = CNT_W'(ctl_q.idx) + CNT_W'(1) - ctl_q.need;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        set_en     = 1'b0;
        clr_en     = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                clr_en = free_req;
                if (alloc_req) begin
                    ctl_d.seg   = calc_seg;
                    ctl_d.fsize = calc_size;
                    ctl_d.units = calc_units;
                    ctl_d.base  = cfg_base;
                    ctl_d.lim   = eff_lim;
                    ctl_d.idx   = '0;
                    ctl_d.run   = '0;
                    if (too_big) begin
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.need  = CNT_W'(calc_units);
                        ctl_d.state = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (bit_free && (run_inc == ctl_q.need)) begin
                    ctl_d.start = IDX_W'(start_full);
                    ctl_d.addr  = ctl_q.base + (ADDR_W'(ctl_d.start) << UNIT_LG);
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                    set_en      = 1'b1;
                end else if (CNT_W'(ctl_q.idx) == ctl_q.lim - CNT_W'(1)) begin
                    ctl_d.err   = 1'b1;
                    ctl_d.state = ST_IDLE;
                end else begin
                    ctl_d.run = bit_free ? run_inc : '0;
                    ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.state == ST_SCAN);
    assign done       = ctl_q.done;
    assign err        = ctl_q.err;
    assign resp_addr  = ctl_q.addr;
    assign resp_start = ctl_q.start;
    assign resp_units = ctl_q.units;
    assign resp_seg   = ctl_q.seg;
    assign resp_size  = ctl_q.fsize;

    // Checker-side state: length of the current busy stretch, and the granted run
    logic [CNT_W:0]      busy_run_q;
    logic [MAP_BITS-1:0] resp_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy) begin
            busy_run_q <= busy_run_q + (CNT_W+1)'(1);
        end else begin
            busy_run_q <= '0;
        end
    end

    for (genvar g = 0; g < MAP_BITS; g++) begin : g_resp
        assign resp_mask[g] = in_run(32'(g), 32'(ctl_q.start), 32'(ctl_q.units));
    end

    assert_resp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= (CNT_W+1)'(MAP_BITS));

    assert_grant_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((map_q & resp_mask) == resp_mask));

    assert_grant_in_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((32'(resp_start) + 32'(resp_units)) <= 32'(ctl_q.lim)));

    assert_fast_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && alloc_req && too_big) |=> (err && !busy && !done));

    assert_scan_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(map_q));

    assert_miss_keeps_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err && $past(busy)) |-> $stable(map_q));

endmodule

// File: tb/fifo_space_alloc_tb_top.sv
`timescale 1ns/1ps
module fifo_space_alloc_tb_top;

    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int N_VEC = 20;

    // {op(2: 0 request, 1 release), p1(16), p2(8), expect refusal(1), expect start(8)}
    localparam logic [34:0] VEC [N_VEC] = '{
        {2'd0, 16'd1024,  8'd2,   1'b0, 8'd0},
        {2'd0, 16'd512,   8'd1,   1'b0, 8'd6},
        {2'd0, 16'd64,    8'd0,   1'b0, 8'd8},
        {2'd0, 16'd1000,  8'd3,   1'b0, 8'd9},
        {2'd1, 16'd6,     8'd2,   1'b0, 8'd0},
        {2'd0, 16'd600,   8'd0,   1'b0, 8'd6},
        {2'd1, 16'd0,     8'd6,   1'b0, 8'd0},
        {2'd0, 16'd3,     8'd15,  1'b0, 8'd0},
        {2'd0, 16'd1024,  8'd4,   1'b0, 8'd17},
        {2'd0, 16'd0,     8'd0,   1'b0, 8'd1},
        {2'd0, 16'd513,   8'd1,   1'b0, 8'd2},
        {2'd0, 16'd32768, 8'd1,   1'b1, 8'd0},
        {2'd0, 16'd1025,  8'd15,  1'b0, 8'd27},
        {2'd0, 16'd16384, 8'd1,   1'b1, 8'd0},
        {2'd0, 16'd2048,  8'd8,   1'b0, 8'd91},
        {2'd0, 16'd100,   8'd0,   1'b0, 8'd127},
        {2'd0, 16'd64,    8'd0,   1'b1, 8'd0},
        {2'd1, 16'd120,   8'd200, 1'b0, 8'd0},
        {2'd0, 16'd1024,  8'd7,   1'b1, 8'd0},
        {2'd0, 16'd4096,  8'd0,   1'b0, 8'd120}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_base;
    logic [7:0]  cfg_limit;
    logic        alloc_req;
    logic [15:0] alloc_maxp;
    logic [3:0]  alloc_slots;
    logic        free_req;
    logic [6:0]  free_start;
    logic [7:0]  free_count;
    logic        busy, done, err;
    logic [31:0] resp_addr;
    logic [6:0]  resp_start;
    logic [11:0] resp_units;
    logic [16:0] resp_seg;
    logic [20:0] resp_size;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fifo_space_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .alloc_req(alloc_req), .alloc_maxp(alloc_maxp), .alloc_slots(alloc_slots),
        .free_req(free_req), .free_start(free_start), .free_count(free_count),
        .busy(busy), .done(done), .err(err), .resp_addr(resp_addr),
        .resp_start(resp_start), .resp_units(resp_units), .resp_seg(resp_seg),
        .resp_size(resp_size)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint bseg(input int maxp);
        longint s = 1;
        while (s < maxp) s = s * 2;
        return s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_resp(output bit g_done, output bit g_err, output int lat,
                             output int bcnt);
        lat  = 1;
        bcnt = 0;
        while (!done && !err && lat < 400) begin
            if (busy) bcnt++;
            @(negedge clk);
            lat++;
        end
        g_done = done;
        g_err  = err;
    endtask

    task automatic run_alloc(input int maxp, input int slots, output bit g_done,
                             output bit g_err, output int lat, output int bcnt);
        @(negedge clk);
        alloc_req   = 1'b1;
        alloc_maxp  = maxp[15:0];
        alloc_slots = slots[3:0];
        @(negedge clk);
        alloc_req = 1'b0;
        wait_resp(g_done, g_err, lat, bcnt);
    endtask

    task automatic do_free(input int start, input int count);
        @(negedge clk);
        free_req   = 1'b1;
        free_start = start[6:0];
        free_count = count[7:0];
        @(negedge clk);
        free_req = 1'b0;
    endtask

    task automatic check_alloc(input int maxp, input int slots, input bit xerr,
                               input int xstart, input int lim);
        bit     gd, ge;
        int     lat, bcnt;
        longint s, sz, u;
        s  = bseg(maxp);
        sz = (slots + 1) * s;
        u  = (sz + 511) / 512;
        run_alloc(maxp, slots, gd, ge, lat, bcnt);
        chk("R5 refusal flag", ge, xerr);
        chk("R3 grant flag", gd, !xerr);
        chk("R1 segment size", resp_seg, s);
        chk("R2 buffer size", resp_size, sz);
        chk("R2 unit count", resp_units, u);
        if (!xerr) begin
            chk("R3 start unit", resp_start, xstart);
            chk("R3 address", resp_addr, longint'(BASE) + xstart * 512);
            chk("R9 busy cycles on grant", bcnt, xstart + u);
        end else if (u > lim) begin
            chk("R6 refusal latency", lat, 1);
            chk("R6 no scan", bcnt, 0);
        end else begin
            chk("R9 busy cycles on miss", bcnt, lim);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual=hung expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit gd, ge;
        int lat, bcnt;
        rst_n       = 1'b0;
        cfg_base    = BASE;
        cfg_limit   = 8'd128;
        alloc_req   = 1'b0;
        alloc_maxp  = '0;
        alloc_slots = '0;
        free_req    = 1'b0;
        free_start  = '0;
        free_count  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 busy after reset", busy, 0);
        chk("R11 done after reset", done, 0);
        chk("R11 err after reset", err, 0);
        chk("R11 address after reset", resp_addr, 0);
        chk("R11 start after reset", resp_start, 0);

        // Vector table: fill, punch holes, refill, overflow, clipped release
        for (int i = 0; i < N_VEC; i++) begin
            if (VEC[i][34:33] == 2'd1) begin
                do_free(int'(VEC[i][32:17]), int'(VEC[i][16:9]));
            end else begin
                check_alloc(int'(VEC[i][32:17]), int'(VEC[i][16:9]), VEC[i][8],
                            int'(VEC[i][7:0]), 128);
            end
        end

        // R6: more units than the pool can ever hold
        check_alloc(65535, 1, 1'b1, 0, 128);

        // R9: minimum latency and single-cycle pulse
        do_reset();
        run_alloc(64, 0, gd, ge, lat, bcnt);
        chk("R9 grant latency", lat, 2);
        chk("R9 one busy cycle", bcnt, 1);
        @(negedge clk);
        chk("R9 done pulse width", done, 0);

        // R8: small usable length
        do_reset();
        cfg_limit = 8'd4;
        check_alloc(512, 1, 1'b0, 0, 4);
        check_alloc(512, 1, 1'b0, 2, 4);
        check_alloc(64, 0, 1'b1, 0, 4);

        // R8: usable length above the map is clamped
        do_reset();
        cfg_limit = 8'd200;
        check_alloc(65535, 0, 1'b0, 0, 128);
        check_alloc(64, 0, 1'b1, 0, 128);

        // R10: release and request raised during a scan are ignored
        do_reset();
        cfg_limit = 8'd128;
        check_alloc(512, 1, 1'b0, 0, 128);
        @(negedge clk);
        alloc_req   = 1'b1;
        alloc_maxp  = 16'd2048;
        alloc_slots = 4'd0;
        @(negedge clk);
        free_req   = 1'b1;
        free_start = 7'd0;
        free_count = 8'd2;
        @(negedge clk);
        alloc_req = 1'b0;
        free_req  = 1'b0;
        wait_resp(gd, ge, lat, bcnt);
        chk("R10 scan grant", gd, 1);
        chk("R10 scan start", resp_start, 2);
        repeat (3) begin
            @(negedge clk);
            chk("R10 no extra response", done | err, 0);
        end
        check_alloc(512, 1, 1'b0, 6, 128);

        // R12: same-cycle release and request
        @(negedge clk);
        free_req    = 1'b1;
        free_start  = 7'd0;
        free_count  = 8'd2;
        alloc_req   = 1'b1;
        alloc_maxp  = 16'd512;
        alloc_slots = 4'd1;
        @(negedge clk);
        free_req  = 1'b0;
        alloc_req = 1'b0;
        wait_resp(gd, ge, lat, bcnt);
        chk("R12 grant", gd, 1);
        chk("R12 released units reused", resp_start, 0);

        // R7: release of free units, then an exact release
        do_free(40, 10);
        check_alloc(512, 1, 1'b0, 8, 128);
        do_free(2, 4);
        check_alloc(600, 1, 1'b0, 2, 128);
        check_alloc(64, 0, 1'b0, 10, 128);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule